// File: doc/BRIEF.md
# Location-Indexed Residual Tag Array

This unit holds the tags, valid bits and replacement state of a small set-associative store that keeps the second 32-byte half of lines that could not be compressed into the main last-level cache's half-size data slot. Each residual entry holds one 32-byte block. Its key is not a memory address. It is the position of the owning line inside the main cache: a main-cache set index plus a main-cache way number.

The residual store has fewer sets than the main cache. The low bits of the main set index choose the residual set. The remaining upper set bits, concatenated with the main way number, form the stored tag. Three request ports act on the array every cycle, in a fixed order:

- **Invalidate.** Driven when the main cache evicts a line.
- **Lookup.** Driven on a read that hits an uncompressed main-cache line.
- **Allocate.** Driven on a fill of a line that would not compress.

The residual store picks its own victims with a tree pseudo-LRU in each set. When it evicts an entry to make room, it reports the main-cache slot that lost its second half. The main cache keeps that line, which then gives only partial hits.

Top module: `residual_tag_array`

## Requirements
- R1: After a synchronous active-low reset, every entry is invalid, `lkp_hit`, `alc_done` and `alc_evict` are 0, and any lookup misses.
- R2: The residual set is main set index modulo RES_SETS (its low bits). The tag is {main set index divided by RES_SETS, main way}. Two slots hit the same entry only if both set index and way are equal; slots that share only the low set bits, or only the way, do not alias.
- R3: A lookup reports its result on the clock edge after the request. `lkp_hit` is 1 with `lkp_rway` set to the residual way holding the slot, or `lkp_hit` is 0.
- R4: An allocation into a set with an invalid way fills the lowest-numbered invalid way. It reports `alc_done`=1, that way on `alc_rway`, and `alc_evict`=0 on the next edge.
- R5: An allocation into a full set replaces the tree pseudo-LRU victim and reports `alc_evict`=1 with the evicted entry's main slot on `alc_vic_set`/`alc_vic_way`. The tree has RES_WAYS-1 bits in heap order, node 1 at the root, all reset to 0. The victim walk starts at node 1 and goes to child 2n+b, where b is node n's bit; the visited bits, MSB first, give the victim way. No other entry changes.
- R6: A lookup hit and an allocation both mark their way most recently used: every node on the path to that way is set to point away from it. Within one cycle the lookup's update is applied before the allocation chooses its victim.
- R7: An invalidate clears the entry tagged with its slot. An invalidate of a slot that is not present changes no entry.
- R8: The three ports act in the order invalidate, lookup, allocate. A lookup to a slot invalidated in the same cycle misses. An allocation sees the entry already freed.
- R9: Allocating a slot that is already present reuses its way with `alc_evict`=0 and never creates a second copy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inv_en | input | 1 | Main cache evicted a line |
| inv_set | input | log2(MAIN_SETS) | Main set of the evicted line |
| inv_way | input | log2(MAIN_WAYS) | Main way of the evicted line |
| lkp_en | input | 1 | Lookup request |
| lkp_set | input | log2(MAIN_SETS) | Main set of the line looked up |
| lkp_way | input | log2(MAIN_WAYS) | Main way of the line looked up |
| lkp_hit | output | 1 | Registered lookup hit |
| lkp_rway | output | log2(RES_WAYS) | Residual way of the hit |
| alc_en | input | 1 | Allocate for an uncompressible fill |
| alc_set | input | log2(MAIN_SETS) | Main set of the filled line |
| alc_way | input | log2(MAIN_WAYS) | Main way of the filled line |
| alc_done | output | 1 | Registered: an allocation happened |
| alc_rway | output | log2(RES_WAYS) | Residual way written |
| alc_evict | output | 1 | A valid entry was replaced |
| alc_vic_set | output | log2(MAIN_SETS) | Main set whose residual half was dropped |
| alc_vic_way | output | log2(MAIN_WAYS) | Main way whose residual half was dropped |

## Verification
The hardest state to reach is a full residual set whose pseudo-LRU bits were shaped by a mix of lookup hits and allocations, with an invalidate or a lookup landing on the same set in the same cycle as the allocation. The bench runs a reduced configuration: 16 main sets, 4 main ways, and 4 residual sets of 4 ways. This squeezes sixteen slots onto each residual set, so full sets and evictions come quickly. Directed sequences build each same-cycle collision. A long pseudo-random mix of all three ports, checked against an arithmetic model, then covers the remaining interleavings. A final sweep invalidates every slot and confirms that all of them miss.

// File: rtl/rta_pkg.sv
// Package: shared types for the residual tag array.
// Assumes nothing beyond being compiled first.
package rta_pkg;
    // Where an allocation takes its residual way from.
    typedef enum logic [1:0] {
        SRC_REUSE = 2'd0,
        SRC_FREE  = 2'd1,
        SRC_EVICT = 2'd2
    } alloc_src_e;
endpackage

// File: rtl/rta_way_match.sv
// Module: compares one set's stored tags with a key.
// Returns a per-way hit vector gated by the valid bits.
// Assumes tags are packed way-major.
module rta_way_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 6
) (
    input  logic [WAYS-1:0]             vld,
    input  logic [WAYS-1:0][TAG_W-1:0]  tags,
    input  logic [TAG_W-1:0]            key,
    output logic [WAYS-1:0]             hitv
);
    // One comparator per way.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hitv[w] = vld[w] && (tags[w] == key);
    end
endmodule

// File: rtl/rta_plru_pick.sv
// Module: walks a heap-ordered pseudo-LRU tree and names the victim way.
// Assumes WAYS is a power of two, at least 2.
module rta_plru_pick #(
    parameter int WAYS = 4,
    localparam int LV = $clog2(WAYS)
) (
    input  logic [WAYS-2:0] state,
    output logic [LV-1:0]   victim
);
    // Follow each node's bit from the root down to a leaf.
    always_comb begin
        int node;
        node   = 1;
        victim = '0;
        for (int lv = 0; lv < LV; lv++) begin
            victim[LV-1-lv] = state[node-1];
            node = node * 2 + int'(state[node-1]);
        end
    end
endmodule

// File: rtl/rta_plru_touch.sv
// Module: marks one way most recently used.
// Every node on the way's path is set to point away from it.
// Assumes WAYS is a power of two, at least 2.
module rta_plru_touch #(
    parameter int WAYS = 4,
    localparam int LV = $clog2(WAYS)
) (
    input  logic [WAYS-2:0] state,
    input  logic [LV-1:0]   way,
    output logic [WAYS-2:0] next
);
    // Flip each node on the path away from the touched way.
    always_comb begin
        int node;
        node = 1;
        next = state;
        for (int lv = 0; lv < LV; lv++) begin
            next[node-1] = ~way[LV-1-lv];
            node = node * 2 + int'(way[LV-1-lv]);
        end
    end
endmodule

// File: rtl/residual_tag_array.sv
// Module: tag, valid and pseudo-LRU store for residual halves.
// Entries are keyed by main-cache slot (set, way).
// Each cycle applies invalidate, then lookup, then allocate.
// Results are registered.
// Assumes MAIN_SETS > RES_SETS, all sizes are powers of two,
// and the main cache never allocates a slot it has not evicted.
module residual_tag_array #(
    parameter int MAIN_SETS = 1024,
    parameter int MAIN_WAYS = 8,
    parameter int RES_SETS  = 128,
    parameter int RES_WAYS  = 4,
    localparam int MS_W  = $clog2(MAIN_SETS),
    localparam int MW_W  = $clog2(MAIN_WAYS),
    localparam int RI_W  = $clog2(RES_SETS),
    localparam int RW_W  = $clog2(RES_WAYS),
    localparam int UP_W  = MS_W - RI_W,
    localparam int TAG_W = UP_W + MW_W,
    localparam int PL_W  = RES_WAYS - 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            inv_en,
    input  logic [MS_W-1:0] inv_set,
    input  logic [MW_W-1:0] inv_way,
    input  logic            lkp_en,
    input  logic [MS_W-1:0] lkp_set,
    input  logic [MW_W-1:0] lkp_way,
    output logic            lkp_hit,
    output logic [RW_W-1:0] lkp_rway,
    input  logic            alc_en,
    input  logic [MS_W-1:0] alc_set,
    input  logic [MW_W-1:0] alc_way,
    output logic            alc_done,
    output logic [RW_W-1:0] alc_rway,
    output logic            alc_evict,
    output logic [MS_W-1:0] alc_vic_set,
    output logic [MW_W-1:0] alc_vic_way
);
    import rta_pkg::*;

    logic [RES_WAYS-1:0]             vld_q  [RES_SETS];
    logic [RES_WAYS-1:0][TAG_W-1:0]  tag_q  [RES_SETS];
    logic [PL_W-1:0]                 plru_q [RES_SETS];

    // Split each slot key into residual index and tag.
    logic [RI_W-1:0]  inv_idx, lk_idx, al_idx;
    logic [TAG_W-1:0] inv_tag, lk_tag, al_tag;
    assign inv_idx = inv_set[RI_W-1:0];
    assign lk_idx  = lkp_set[RI_W-1:0];
    assign al_idx  = alc_set[RI_W-1:0];
    assign inv_tag = {inv_set[MS_W-1:RI_W], inv_way};
    assign lk_tag  = {lkp_set[MS_W-1:RI_W], lkp_way};
    assign al_tag  = {alc_set[MS_W-1:RI_W], alc_way};

    // Invalidate stage: find the entry the main cache just evicted.
    logic [RES_WAYS-1:0] inv_raw, inv_hitv;
    rta_way_match #(.WAYS(RES_WAYS), .TAG_W(TAG_W)) u_inv_match (
        .vld(vld_q[inv_idx]), .tags(tag_q[inv_idx]), .key(inv_tag), .hitv(inv_raw)
    );
    assign inv_hitv = inv_en ? inv_raw : '0;

    // Valid rows as seen after the invalidate is applied.
    logic [RES_WAYS-1:0] lk_vld, al_vld;
    assign lk_vld = vld_q[lk_idx] & ~((inv_idx == lk_idx) ? inv_hitv : '0);
    assign al_vld = vld_q[al_idx] & ~((inv_idx == al_idx) ? inv_hitv : '0);

    // Lookup stage: match and encode the hit way.
    logic [RES_WAYS-1:0] lk_raw;
    logic                lk_hit;
    logic [RW_W-1:0]     lk_way;
    rta_way_match #(.WAYS(RES_WAYS), .TAG_W(TAG_W)) u_lk_match (
        .vld(lk_vld), .tags(tag_q[lk_idx]), .key(lk_tag), .hitv(lk_raw)
    );
    assign lk_hit = lkp_en && (|lk_raw);

    // Encode the one-hot lookup match as a way number.
    always_comb begin
        lk_way = '0;
        for (int w = 0; w < RES_WAYS; w++)
            if (lk_raw[w]) lk_way = RW_W'(w);
    end

    // Replacement state after the lookup's own update.
    logic [PL_W-1:0] lk_plru_nx;
    rta_plru_touch #(.WAYS(RES_WAYS)) u_lk_touch (
        .state(plru_q[lk_idx]), .way(lk_way), .next(lk_plru_nx)
    );

    // Allocate stage: reuse a match, else a free way, else the victim.
    logic [RES_WAYS-1:0] al_hitv;
    logic [PL_W-1:0]     al_base, al_plru_nx;
    logic [RW_W-1:0]     al_victim, al_free, al_hitway, al_way;
    alloc_src_e          al_src;
    rta_way_match #(.WAYS(RES_WAYS), .TAG_W(TAG_W)) u_al_match (
        .vld(al_vld), .tags(tag_q[al_idx]), .key(al_tag), .hitv(al_hitv)
    );
    assign al_base = (lk_hit && lk_idx == al_idx) ? lk_plru_nx : plru_q[al_idx];
    rta_plru_pick #(.WAYS(RES_WAYS)) u_al_pick (
        .state(al_base), .victim(al_victim)
    );

    // Lowest invalid way and encoded reuse way.
    always_comb begin
        al_free   = '0;
        al_hitway = '0;
        for (int w = RES_WAYS - 1; w >= 0; w--)
            if (!al_vld[w]) al_free = RW_W'(w);
        for (int w = 0; w < RES_WAYS; w++)
            if (al_hitv[w]) al_hitway = RW_W'(w);
    end

    // Choose where the allocation lands.
    always_comb begin
        if (|al_hitv) begin
            al_src = SRC_REUSE;
            al_way = al_hitway;
        end else if (!(&al_vld)) begin
            al_src = SRC_FREE;
            al_way = al_free;
        end else begin
            al_src = SRC_EVICT;
            al_way = al_victim;
        end
    end

    rta_plru_touch #(.WAYS(RES_WAYS)) u_al_touch (
        .state(al_base), .way(al_way), .next(al_plru_nx)
    );

    // Main slot of the entry being replaced.
    logic [TAG_W-1:0] vic_tag;
    assign vic_tag = tag_q[al_idx][al_way];

    // Valid bits and replacement state, written in port order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < RES_SETS; s++) begin
                vld_q[s]  <= '0;
                plru_q[s] <= '0;
            end
        end else begin
            if (|inv_hitv) vld_q[inv_idx] <= vld_q[inv_idx] & ~inv_hitv;
            if (lk_hit)    plru_q[lk_idx] <= lk_plru_nx;
            if (alc_en) begin
                vld_q[al_idx]  <= al_vld | (RES_WAYS'(1) << al_way);
                plru_q[al_idx] <= al_plru_nx;
            end
        end
    end

    // Tag storage, written on allocation only.
    always_ff @(posedge clk) begin
        if (alc_en) tag_q[al_idx][al_way] <= al_tag;
    end

    // Registered results for both request ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lkp_hit     <= 1'b0;
            lkp_rway    <= '0;
            alc_done    <= 1'b0;
            alc_rway    <= '0;
            alc_evict   <= 1'b0;
            alc_vic_set <= '0;
            alc_vic_way <= '0;
        end else begin
            lkp_hit   <= lk_hit;
            lkp_rway  <= lk_hit ? lk_way : '0;
            alc_done  <= alc_en;
            alc_rway  <= alc_en ? al_way : '0;
            alc_evict <= alc_en && (al_src == SRC_EVICT);
            if (alc_en && al_src == SRC_EVICT) begin
                alc_vic_set <= {vic_tag[TAG_W-1:MW_W], al_idx};
                alc_vic_way <= vic_tag[MW_W-1:0];
            end else begin
                alc_vic_set <= '0;
                alc_vic_way <= '0;
            end
        end
    end

    // R9: a slot never sits in two ways of one set.
    p_single_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(al_hitv));

    // R9: reusing a present slot never evicts.
    p_reuse_no_evict_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (alc_en && |al_hitv) |=> (alc_done && !alc_evict));

    // R8: an invalidate beats a same-cycle lookup of the same slot.
    p_inv_beats_lookup_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_en && lkp_en && inv_set == lkp_set && inv_way == lkp_way) |=> !lkp_hit);

    // R3: a slot allocated one cycle is found by a lookup the next.
    p_alloc_then_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        alc_en ##1 (lkp_en && !inv_en && lkp_set == $past(alc_set)
                    && lkp_way == $past(alc_way)) |=> lkp_hit);

    // R4: no eviction while the set still had an invalid way.
    p_free_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (alc_en && !(&al_vld)) |=> !alc_evict);

    // R7: the invalidated entry is clear on the next cycle.
    p_inv_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|inv_hitv && !alc_en) |=> ((vld_q[$past(inv_idx)] & $past(inv_hitv)) == '0));

    // R1: lookup and allocate results only follow a request.
    p_hit_needs_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_hit |-> $past(lkp_en));
endmodule

// File: tb/residual_tag_array_test.sv
// Bench: reduced configuration (16 main sets x 4 ways, 4 residual sets x 4 ways).
// Every result is checked against an arithmetic model of the requirements.
module residual_tag_array_test;
    localparam int MSETS = 16, MWAYS = 4, RSETS = 4, RWAYS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       inv_en = 1'b0, lkp_en = 1'b0, alc_en = 1'b0;
    logic [3:0] inv_set = '0, lkp_set = '0, alc_set = '0;
    logic [1:0] inv_way = '0, lkp_way = '0, alc_way = '0;
    logic       lkp_hit, alc_done, alc_evict;
    logic [1:0] lkp_rway, alc_rway, alc_vic_way;
    logic [3:0] alc_vic_set;

    int tests = 0, fails = 0;

    residual_tag_array #(.MAIN_SETS(MSETS), .MAIN_WAYS(MWAYS),
                         .RES_SETS(RSETS), .RES_WAYS(RWAYS)) uut (
        .clk(clk), .rst_n(rst_n),
        .inv_en(inv_en), .inv_set(inv_set), .inv_way(inv_way),
        .lkp_en(lkp_en), .lkp_set(lkp_set), .lkp_way(lkp_way),
        .lkp_hit(lkp_hit), .lkp_rway(lkp_rway),
        .alc_en(alc_en), .alc_set(alc_set), .alc_way(alc_way),
        .alc_done(alc_done), .alc_rway(alc_rway), .alc_evict(alc_evict),
        .alc_vic_set(alc_vic_set), .alc_vic_way(alc_vic_way)
    );

    always #5 clk = ~clk;

    // Model state: valid, tag {set/4, way}, tree bits {right, left, root}.
    bit         mv [RSETS][RWAYS];
    logic [3:0] mt [RSETS][RWAYS];
    logic [2:0] mp [RSETS];

    function automatic logic [2:0] touch(logic [2:0] p, int w);
        logic [2:0] r;
        r = p;
        r[0] = (w < 2);
        if (w < 2) r[1] = (w == 0);
        else       r[2] = (w == 2);
        return r;
    endfunction

    function automatic int pick(logic [2:0] p);
        if (p[0] == 1'b0) return p[1] ? 1 : 0;
        return p[2] ? 3 : 2;
    endfunction

    task automatic check(string rq, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    // One cycle: drive, update the model in port order, then compare after the edge.
    task automatic step(string rq, bit ie, int is, int iw, bit le, int ls, int lw,
                        bit ae, int as, int aw);
        int  e_lh = 0, e_lw = 0, e_ad = 0, e_aw = 0, e_ev = 0, e_vs = 0, e_vw = 0;
        int  x, t, wsel, found;
        inv_en = ie; inv_set = 4'(is); inv_way = 2'(iw);
        lkp_en = le; lkp_set = 4'(ls); lkp_way = 2'(lw);
        alc_en = ae; alc_set = 4'(as); alc_way = 2'(aw);
        if (ie) begin
            x = is % RSETS; t = (is / RSETS) * 4 + iw;
            for (int w = 0; w < RWAYS; w++)
                if (mv[x][w] && mt[x][w] == 4'(t)) mv[x][w] = 0;
        end
        if (le) begin
            x = ls % RSETS; t = (ls / RSETS) * 4 + lw;
            for (int w = 0; w < RWAYS; w++)
                if (mv[x][w] && mt[x][w] == 4'(t)) begin
                    e_lh = 1; e_lw = w;
                end
            if (e_lh == 1) mp[x] = touch(mp[x], e_lw);
        end
        if (ae) begin
            x = as % RSETS; t = (as / RSETS) * 4 + aw;
            e_ad = 1; found = 0; wsel = 0;
            for (int w = 0; w < RWAYS; w++)
                if (found == 0 && mv[x][w] && mt[x][w] == 4'(t)) begin
                    found = 1; wsel = w;
                end
            for (int w = 0; w < RWAYS; w++)
                if (found == 0 && !mv[x][w]) begin
                    found = 1; wsel = w;
                end
            if (found == 0) begin
                wsel = pick(mp[x]); e_ev = 1;
                e_vs = int'(mt[x][wsel] / 4) * RSETS + x;
                e_vw = int'(mt[x][wsel] % 4);
            end
            e_aw = wsel;
            mv[x][wsel] = 1; mt[x][wsel] = 4'(t);
            mp[x] = touch(mp[x], wsel);
        end
        @(posedge clk); #1;
        check(rq, "lookup hit", int'(lkp_hit), e_lh);
        if (e_lh == 1) check(rq, "lookup way", int'(lkp_rway), e_lw);
        check(rq, "alloc done", int'(alc_done), e_ad);
        if (ae) begin
            check(rq, "alloc way", int'(alc_rway), e_aw);
            check(rq, "alloc evict", int'(alc_evict), e_ev);
            if (e_ev == 1) begin
                check(rq, "victim set", int'(alc_vic_set), e_vs);
                check(rq, "victim way", int'(alc_vic_way), e_vw);
            end
        end
    endtask

    task automatic look(string rq, int s, int w);
        step(rq, 0, 0, 0, 1, s, w, 0, 0, 0);
    endtask

    task automatic alloc(string rq, int s, int w);
        step(rq, 0, 0, 0, 0, 0, 0, 1, s, w);
    endtask

    task automatic inval(string rq, int s, int w);
        step(rq, 1, s, w, 0, 0, 0, 0, 0, 0);
    endtask

    // Watchdog: a hung run is a failure but still reports.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] rng;
        int          v;
        for (int s = 0; s < RSETS; s++) begin
            mp[s] = '0;
            for (int w = 0; w < RWAYS; w++) begin
                mv[s][w] = 0; mt[s][w] = '0;
            end
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        check("R1", "hit after reset", int'(lkp_hit), 0);
        check("R1", "done after reset", int'(alc_done), 0);
        check("R1", "evict after reset", int'(alc_evict), 0);
        look("R1", 0, 0);
        look("R1", 15, 3);

        // R3/R4: fill and find.
        alloc("R4", 5, 1);
        look("R3", 5, 1);
        // R2: same low set bits or same way do not alias.
        look("R2", 13, 1);
        look("R2", 5, 2);
        look("R2", 1, 1);
        alloc("R4", 13, 1);
        alloc("R4", 9, 0);
        alloc("R4", 1, 3);
        look("R2", 13, 1);
        // R5/R6: lookups steer the victim of a full set.
        look("R6", 5, 1);
        look("R6", 9, 0);
        alloc("R5", 1, 0);
        alloc("R5", 5, 2);
        look("R5", 1, 3);
        // R9: present slot reuses its way.
        alloc("R9", 1, 0);
        // R7: present and absent invalidates.
        inval("R7", 1, 0);
        look("R7", 1, 0);
        inval("R7", 7, 3);
        look("R7", 5, 2);
        // R8: same-cycle invalidate versus lookup and allocate.
        step("R8", 1, 5, 2, 1, 5, 2, 0, 0, 0);
        alloc("R8", 2, 2);
        step("R8", 1, 2, 2, 1, 2, 2, 1, 2, 2);
        look("R8", 2, 2);
        // R6: lookup and allocate to one full set in the same cycle.
        for (int w = 0; w < 4; w++) alloc("R6", 3 + 4 * w, 0);
        step("R6", 0, 0, 0, 1, 3, 0, 1, 3, 1);

        // Pseudo-random mix over all three ports.
        rng = 32'h1234_5678;
        for (int i = 0; i < 4000; i++) begin
            bit ie, le, ae;
            rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
            v = int'(rng);
            ie = (rng[1:0] == 2'd0);
            le = rng[2];
            ae = (rng[4:3] != 2'd0) && rng[5];
            step("R5_R6_R7_R8_R9", ie, int'(rng[9:6]), int'(rng[11:10]),
                 le, int'(rng[15:12]), int'(rng[17:16]),
                 ae, int'(rng[21:18]), int'(rng[23:22]));
            if (v == 0) i = i;
        end

        // Exhaustive sweep: clear every slot, then every lookup misses.
        for (int s = 0; s < MSETS; s++)
            for (int w = 0; w < MWAYS; w++) inval("R7", s, w);
        for (int s = 0; s < MSETS; s++)
            for (int w = 0; w < MWAYS; w++) look("R7", s, w);

        // Reset clears a populated array.
        alloc("R1", 6, 2);
        rst_n = 1'b0;
        for (int s = 0; s < RSETS; s++) begin
            mp[s] = '0;
            for (int w = 0; w < RWAYS; w++) mv[s][w] = 0;
        end
        step("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        rst_n = 1'b1;
        look("R1", 6, 2);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule